// File: doc/BRIEF.md
# Scrolling Note History Display

This block keeps a record of the most recent notes that a playback sequencer has started, and shows them on a row of multiplexed seven-segment digits. Each time the sequencer starts a note, it offers the note code on a valid/ready stream input. The stored record then moves one digit to the left, and the new code lands in the rightmost digit. The note being played is therefore always on the right, and older notes fall off the left end.

The digits are lit one at a time. Each digit stays lit for a fixed number of clock cycles, and then the scan moves to the next digit to the left, wrapping from the leftmost digit back to the rightmost. Digit selects and segment lines are both active low. The segment value for a digit is captured at the instant that digit is selected, so a note arriving in the middle of a dwell never changes a lit digit part-way through. New history contents appear from the next scanned digit onward.

The stream input never applies back-pressure: `note_ready` is high at all times, including during reset. Every cycle with `note_valid` high is one accepted note. `note_code` only has meaning in a cycle where `note_valid` is high.

Top module: `note_history_display`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, all digit selects and all segment lines are high (nothing lit). Every history position holds code 0.
- R2: In each cycle with `note_valid` high, the history shifts by one place. Position k+1 takes the old value of position k, position 0 (the rightmost digit, select bit 0) takes `note_code`, and the oldest value is dropped. In cycles without `note_valid`, the history does not change.
- R3: `note_ready` is high in every cycle.
- R4: Segments are ordered {g,f,e,d,c,b,a} from bit 6 down to bit 0 and are active low. Codes 1 to 8 show the numerals 1 to 8: active-high patterns 06, 5B, 4F, 66, 6D, 7D, 07 and 7F hex.
- R5: A position holding code 0 or any code from 9 to 15 shows all segments high (blank).
- R6: From the first clock edge after reset onward, exactly one select bit is low. The scan starts at bit 0 and moves up one bit at each step, wrapping from bit N-1 back to bit 0.
- R7: Each digit stays selected for exactly DWELL_CYCLES cycles.
- R8: Segment and select outputs change only at a scan step. The segments then show the pattern of the history entry for the newly selected digit, as it stood just before that edge.
- R9: A note accepted in the same cycle as a scan step is not part of the pattern captured at that step. It first appears at the next scan step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| note_valid | input | 1 | A note has started this cycle |
| note_code | input | 4 | Code of the started note (1 to 8 meaningful) |
| note_ready | output | 1 | Always high; the input never stalls |
| dig_sel_n | output | NUM_DIGITS (6) | Active-low digit selects, bit 0 is rightmost |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |

## Verification
Several properties are checked in every cycle:
- at most one select is low, and exactly one after any scan step;
- the dwell counter stays within its limit;
- the outputs stay steady between scan steps;
- the history stays steady when no note is offered;
- out-of-range and empty codes produce blanks.

Only the bench's scenarios can show the visible behaviour. This covers the left-scrolling order of the history, the loss of the oldest note after a burst longer than the display, the exact numeral patterns, and the one-step delay of a note that arrives on a scan step. The bench compares the outputs against its own history model, cycle by cycle, through directed bursts and random traffic.

// File: rtl/nhd_pkg.sv
package nhd_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  // Active-low glyph for a note code, bit order {g,f,e,d,c,b,a}.
  function automatic logic [SEG_W-1:0] glyph_n(input logic [CODE_W-1:0] code);
    logic [SEG_W-1:0] lit;
    case (code)
      4'd1:    lit = 7'h06;
      4'd2:    lit = 7'h5B;
      4'd3:    lit = 7'h4F;
      4'd4:    lit = 7'h66;
      4'd5:    lit = 7'h6D;
      4'd6:    lit = 7'h7D;
      4'd7:    lit = 7'h07;
      4'd8:    lit = 7'h7F;
      default: lit = 7'h00;
    endcase
    return ~lit;
  endfunction
endpackage

// File: rtl/nhd_history.sv
module nhd_history
  import nhd_pkg::*;
#(
  parameter int N = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [CODE_W-1:0]          in_code,
  output logic [N-1:0][CODE_W-1:0]   hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (in_valid) begin
      hist <= {hist[N-2:0], in_code};
    end
  end

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hist));
endmodule

// File: rtl/nhd_scanner.sv
module nhd_scanner #(
  parameter int N     = 6,
  parameter int DWELL = 50000,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             step,
  output logic [IDX_W-1:0] idx_next
);
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  assign step     = (cnt == CNT_W'(DWELL - 1));
  assign idx_next = (idx == IDX_W'(N - 1)) ? '0 : idx + 1'b1;

  // Reset parks the scan one step before digit 0 so the first edge lights it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_W'(DWELL - 1);
      idx <= IDX_W'(N - 1);
    end else if (step) begin
      cnt <= '0;
      idx <= idx_next;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DWELL - 1));
  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(N - 1));
endmodule

// File: rtl/nhd_driver.sv
module nhd_driver
  import nhd_pkg::*;
#(
  parameter int N = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic [IDX_W-1:0]          idx_next,
  input  logic [N-1:0][CODE_W-1:0]  hist,
  output logic [N-1:0]              sel_n,
  output logic [SEG_W-1:0]          seg_n
);
  logic [CODE_W-1:0] code_at;
  assign code_at = hist[idx_next];

  // Outputs are captured only on a scan step, never mid-dwell.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n <= '1;
      seg_n <= '1;
    end else if (step) begin
      sel_n <= ~(N'(1) << idx_next);
      seg_n <= glyph_n(code_at);
    end
  end

  // R8
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(seg_n) && $stable(sel_n)));
  // R6
  one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ($countones(~sel_n) == 1));
  // R6
  at_most_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);
  // R5
  blank_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (code_at == '0 || code_at > CODE_W'(8))) |=> (seg_n == '1));
endmodule

// File: rtl/note_history_display.sv
module note_history_display
  import nhd_pkg::*;
#(
  parameter int NUM_DIGITS   = 6,
  parameter int DWELL_CYCLES = 50000,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  note_valid,
  input  logic [CODE_W-1:0]     note_code,
  output logic                  note_ready,
  output logic [NUM_DIGITS-1:0] dig_sel_n,
  output logic [SEG_W-1:0]      seg_n
);
  logic [NUM_DIGITS-1:0][CODE_W-1:0] hist;
  logic                              step;
  logic [IDX_W-1:0]                  idx_next;

  assign note_ready = 1'b1;

  nhd_history #(.N(NUM_DIGITS)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .in_valid(note_valid), .in_code(note_code),
    .hist(hist)
  );

  nhd_scanner #(.N(NUM_DIGITS), .DWELL(DWELL_CYCLES)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .step(step), .idx_next(idx_next)
  );

  nhd_driver #(.N(NUM_DIGITS)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .step(step), .idx_next(idx_next), .hist(hist),
    .sel_n(dig_sel_n), .seg_n(seg_n)
  );
endmodule

// File: tb/test_note_history_display.sv
module test_note_history_display;
  localparam int N = 6;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       note_valid;
  logic [3:0] note_code;
  logic       note_ready;
  logic [N-1:0] dig_sel_n;
  logic [6:0] seg_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] mh [N];
  int mcnt, midx;
  logic [N-1:0] exp_sel;
  logic [6:0] exp_seg;
  string tag;

  always #5 clk = ~clk;

  note_history_display #(.NUM_DIGITS(N), .DWELL_CYCLES(D)) i_note_history_display (
    .clk(clk), .rst_n(rst_n), .note_valid(note_valid), .note_code(note_code),
    .note_ready(note_ready), .dig_sel_n(dig_sel_n), .seg_n(seg_n)
  );

  function automatic logic [6:0] exp_glyph(input logic [3:0] c);
    logic [6:0] p;
    case (c)
      4'd1: p = 7'b0000110;
      4'd2: p = 7'b1011011;
      4'd3: p = 7'b1001111;
      4'd4: p = 7'b1100110;
      4'd5: p = 7'b1101101;
      4'd6: p = 7'b1111101;
      4'd7: p = 7'b0000111;
      4'd8: p = 7'b1111111;
      default: p = 7'b0000000;
    endcase
    return ~p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) mh[k] = 4'd0;
    mcnt = D - 1;
    midx = N - 1;
    exp_sel = '1;
    exp_seg = '1;
  endtask

  // One cycle: drive at negedge, model the next edge, compare at the next negedge.
  task automatic cyc(input logic v, input logic [3:0] c);
    note_valid = v;
    note_code  = c;
    if (mcnt == D - 1) begin
      midx = (midx + 1) % N;
      exp_sel = ~(N'(1) << midx);
      exp_seg = exp_glyph(mh[midx]);
      mcnt = 0;
    end else begin
      mcnt++;
    end
    if (v) begin
      for (int k = N - 1; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = c;
    end
    @(posedge clk);
    @(negedge clk);
    chk(dig_sel_n == exp_sel, "R6 R7 select", int'(dig_sel_n), int'(exp_sel));
    chk(seg_n == exp_seg, tag, int'(seg_n), int'(exp_seg));
    chk(note_ready == 1'b1, "R3 ready", int'(note_ready), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    tag = "R2 R4 R8 segments";
    rst_n = 1'b0;
    note_valid = 1'b0;
    note_code = 4'd0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: nothing lit during reset, ready still high
    chk(dig_sel_n == '1, "R1 select in reset", int'(dig_sel_n), 'h3F);
    chk(seg_n == '1, "R1 segments in reset", int'(seg_n), 'h7F);
    chk(note_ready == 1'b1, "R3 ready in reset", int'(note_ready), 1);
    rst_n = 1'b1;

    // R1 R5: empty history shows blanks across a full scan
    tag = "R1 R5 empty blank";
    idle(N * D);

    // R2 R4: notes 1..6 fill the display, newest rightmost
    tag = "R2 R4 R8 fill";
    for (int k = 1; k <= 6; k++) cyc(1'b1, 4'(k));
    idle(2 * N * D);

    // R2: burst of 7 and 8 pushes the oldest off the left end
    tag = "R2 R8 scroll";
    cyc(1'b1, 4'd7);
    cyc(1'b1, 4'd8);
    idle(2 * N * D);

    // R5: empty and out-of-range codes blank
    tag = "R5 blank codes";
    cyc(1'b1, 4'd0);
    cyc(1'b1, 4'd9);
    cyc(1'b1, 4'd15);
    idle(2 * N * D);

    // R9: note landing on a scan step
    tag = "R9 coincident note";
    for (int r = 0; r < 8; r++) begin
      while (mcnt != D - 1) cyc(1'b0, 4'd0);
      cyc(1'b1, 4'(1 + r));
      idle(D);
    end
    idle(N * D);

    // Random traffic
    tag = "R2 R4 R8 random";
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 3) == 0;
      cyc(v, 4'($urandom % 16));
    end

    // R1: reset mid-operation clears history
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk(dig_sel_n == '1 && seg_n == '1, "R1 reset again", int'({dig_sel_n, seg_n}), 'h1FFF);
    rst_n = 1'b1;
    tag = "R1 R5 cleared";
    idle(N * D);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule